// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over several clock cycles. It uses one shift-and-subtract step per cycle. The dividend, the partial remainder and the quotient as it builds all live in one double-width register. Beside it sit a single-width divisor register and a single subtractor. The subtractor carries one extra guard bit, so that divisors with the top bit set also divide correctly.

A one-cycle `start_i` pulse captures both operands and the `signed_i` select. In signed mode both operands are first reduced to their magnitudes. After the shift/subtract steps, a correction stage sets the signs of the results. When the result is ready the block pulses `done_o` for one cycle. The remainder then appears on `hi_o` and the quotient on `lo_o`, and both stay unchanged until the next division completes.

The block makes no divide-by-zero or overflow check. A zero divisor runs through the same sequence and returns whatever the datapath produces.

Top module: `seq_divider`

## Requirements
- R1: After reset, `done_o`, `hi_o` and `lo_o` are all zero.
- R2: With `signed_i`=0, both operands are unsigned. When the run completes, `lo_o` holds the truncated quotient and `hi_o` holds the remainder, including operands whose bit 31 is set.
- R3: `done_o` goes high exactly 34 clock edges after the edge that samples `start_i`. This is one load edge, 33 shift steps and one correction edge. It stays high for exactly one cycle.
- R4: `hi_o` and `lo_o` keep their values from one completion until the next completion.
- R5: A `start_i` pulse that arrives while a division is in progress has no effect on the results or on the timing of that division.
- R6: With `signed_i`=1, operands are two's complement. The quotient is the truncated magnitude quotient, negated only when the operand signs differ.
- R7: With `signed_i`=1, the remainder has the magnitude of the magnitude remainder and carries the sign of the dividend.
- R8: With a zero divisor, the magnitude quotient is 0xFFFFFFFF and the magnitude remainder equals the dividend magnitude. The same sign rules as R6/R7 then apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request that captures the operands when the block is idle |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| hi_o | output | 32 | Remainder, held between completions |
| lo_o | output | 32 | Quotient, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due 34 edges after the start edge. `done_o`, `hi_o` and `lo_o` all change on that same edge. The directed tasks count the edges one at a time after the start edge and sample 1 ns after each edge. Each task checks that `done_o` first rises at count 34, then compares both outputs in that same cycle. The hold and ignored-start tasks sample the outputs again several edges later, and check that `done_o` has fallen and the values are unchanged.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         neg_quo_o,
  output logic         neg_rem_o
);
  logic dvd_neg, dvs_neg;

  assign dvd_neg   = signed_i & dvd_i[W-1];
  assign dvs_neg   = signed_i & dvs_i[W-1];
  assign dvd_mag_o = dvd_neg ? (~dvd_i + 1'b1) : dvd_i;
  assign dvs_mag_o = dvs_neg ? (~dvs_i + 1'b1) : dvs_i;
  assign neg_quo_o = dvd_neg ^ dvs_neg;
  assign neg_rem_o = dvd_neg;
endmodule

// File: rtl/div_core.sv
module div_core
  import div_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned AW = 2 * W;

  div_state_e     state_q;
  logic [AW-1:0]  acc_q;
  logic           ext_q;   // bit shifted out of the upper half
  logic [W-1:0]   dvs_q;
  logic [CW-1:0]  cnt_q;
  logic           fin_q;
  logic [W+1:0]   diff;
  logic           fits;

  assign diff = {1'b0, ext_q, acc_q[AW-1:W]} - {2'b00, dvs_q};
  assign fits = ~diff[W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      ext_q   <= 1'b0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            acc_q   <= {{W{1'b0}}, dvd_i};
            ext_q   <= 1'b0;
            dvs_q   <= dvs_i;
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        default: begin
          if (cnt_q == '0)
            {ext_q, acc_q} <= {acc_q, 1'b0};
          else if (fits)
            {ext_q, acc_q} <= {diff[W-1:0], acc_q[W-1:0], 1'b1};
          else
            {ext_q, acc_q} <= {acc_q, 1'b0};
          if (cnt_q == CW'(W)) begin
            state_q <= ST_IDLE;
            fin_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign fin_o  = fin_q;
  assign rem_o  = {ext_q, acc_q[AW-1:W+1]};
  assign quo_o  = acc_q[W-1:0];

  // R3
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != CW'(W)) |=> (state_q == ST_RUN && !fin_q));

  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> $stable(dvs_q));

  // R8
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != '0 && dvs_q == '0) |=> acc_q[0]);
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  assign quo_o = neg_quo_i ? (~quo_i + 1'b1) : quo_i;
  assign rem_o = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         done_o
);
  logic         busy, fin, accept;
  logic [W-1:0] dvd_mag, dvs_mag, core_rem, core_quo, fix_rem, fix_quo;
  logic         neg_quo_d, neg_rem_d, neg_quo_q, neg_rem_q;

  assign accept = start_i & ~busy;

  div_operand_prep #(.W(W)) i_prep (
    .signed_i  (signed_i),
    .dvd_i     (dividend_i),
    .dvs_i     (divisor_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_quo_o (neg_quo_d),
    .neg_rem_o (neg_rem_d)
  );

  div_core #(.W(W)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .busy_o (busy),
    .fin_o  (fin),
    .rem_o  (core_rem),
    .quo_o  (core_quo)
  );

  div_sign_fix #(.W(W)) i_fix (
    .quo_i     (core_quo),
    .rem_i     (core_rem),
    .neg_quo_i (neg_quo_q),
    .neg_rem_i (neg_rem_q),
    .quo_o     (fix_quo),
    .rem_o     (fix_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      hi_o      <= '0;
      lo_o      <= '0;
      done_o    <= 1'b0;
    end else begin
      if (accept) begin
        neg_quo_q <= neg_quo_d;
        neg_rem_q <= neg_rem_d;
      end
      done_o <= fin;
      if (fin) begin
        hi_o <= fix_rem;
        lo_o <= fix_quo;
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> ($stable(hi_o) && $stable(lo_o)));

  // R7
  rem_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && neg_rem_q && hi_o != '0) |-> hi_o[W-1]);

  // R5
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(neg_quo_q) && $stable(neg_rem_q)));
endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 34;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic [31:0] hi_o, lo_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  seq_divider i_seq_divider (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .hi_o       (hi_o),
    .lo_o       (lo_o),
    .done_o     (done_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Pulse start, then count edges until done; returns edge count.
  task automatic run_div(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                         output int lat);
    @(negedge clk_i);
    signed_i   = sgn;
    dividend_i = a;
    divisor_i  = b;
    start_i    = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
    lat = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk_i);
      #1 lat++;
      if (done_o) break;
    end
  endtask

  function automatic logic [31:0] neg32(input logic [31:0] x);
    return ~x + 32'd1;
  endfunction

  task automatic do_unsigned(input logic [31:0] a, input logic [31:0] b);
    int lat;
    run_div(1'b0, a, b, lat);
    check(lat == LATENCY && done_o, "R3 latency", 32'(lat), 32'(LATENCY));
    check(lo_o == a / b, "R2 quotient", lo_o, a / b);
    check(hi_o == a % b, "R2 remainder", hi_o, a % b);
  endtask

  task automatic do_signed(input logic [31:0] a, input logic [31:0] b);
    int lat;
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    q  = sa / sb;
    r  = sa % sb;
    run_div(1'b1, a, b, lat);
    check(lat == LATENCY && done_o, "R3 latency", 32'(lat), 32'(LATENCY));
    check(lo_o == q[31:0], "R6 signed quotient", lo_o, q[31:0]);
    check(hi_o == r[31:0], "R7 signed remainder", hi_o, r[31:0]);
  endtask

  task automatic test_reset;
    check(done_o == 1'b0, "R1 done at reset", {31'd0, done_o}, 32'd0);
    check(hi_o == '0, "R1 hi at reset", hi_o, 32'd0);
    check(lo_o == '0, "R1 lo at reset", lo_o, 32'd0);
  endtask

  task automatic test_unsigned;
    do_unsigned(32'd7, 32'd3);
    do_unsigned(32'd100, 32'd10);
    do_unsigned(32'd5, 32'd9);
    do_unsigned(32'hFFFF_FFFF, 32'd2);
    do_unsigned(32'hFFFF_FFFF, 32'h8000_0001);
    do_unsigned(32'hDEAD_BEEF, 32'h0000_1234);
    do_unsigned(32'h8000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic test_signed;
    do_signed(32'd7, 32'd3);
    do_signed(neg32(32'd7), 32'd3);
    do_signed(32'd7, neg32(32'd3));
    do_signed(neg32(32'd7), neg32(32'd3));
    do_signed(32'h8000_0000, 32'hFFFF_FFFF);
    do_signed(neg32(32'd6), 32'd3);
  endtask

  task automatic test_zero_div;
    int lat;
    run_div(1'b0, 32'd5, 32'd0, lat);
    check(lo_o == 32'hFFFF_FFFF, "R8 unsigned zero quotient", lo_o, 32'hFFFF_FFFF);
    check(hi_o == 32'd5, "R8 unsigned zero remainder", hi_o, 32'd5);
    run_div(1'b1, neg32(32'd5), 32'd0, lat);
    check(lo_o == 32'd1, "R8 signed zero quotient", lo_o, 32'd1);
    check(hi_o == neg32(32'd5), "R8 signed zero remainder", hi_o, neg32(32'd5));
    check(lat == LATENCY, "R8 zero divisor latency", 32'(lat), 32'(LATENCY));
  endtask

  task automatic test_hold;
    logic [31:0] h, l;
    int lat;
    run_div(1'b0, 32'd1000, 32'd7, lat);
    h = hi_o;
    l = lo_o;
    @(posedge clk_i);
    #1 check(done_o == 1'b0, "R3 done one cycle", {31'd0, done_o}, 32'd0);
    signed_i   = 1'b1;
    dividend_i = 32'h1234_5678;
    divisor_i  = 32'd3;
    repeat (5) @(posedge clk_i);
    #1;
    check(hi_o == h, "R4 hi held", hi_o, h);
    check(lo_o == l, "R4 lo held", lo_o, l);
  endtask

  task automatic test_busy_start;
    int lat;
    lat = 0;
    @(negedge clk_i);
    signed_i = 1'b0; dividend_i = 32'd91; divisor_i = 32'd4; start_i = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (i == 5) begin
        signed_i = 1'b1; dividend_i = neg32(32'd50); divisor_i = 32'd7; start_i = 1'b1;
      end
      @(posedge clk_i);
      #1 lat++;
      start_i = 1'b0;
      if (done_o) break;
    end
    check(lat == LATENCY, "R5 latency unchanged", 32'(lat), 32'(LATENCY));
    check(lo_o == 32'd22, "R5 quotient unchanged", lo_o, 32'd22);
    check(hi_o == 32'd3, "R5 remainder unchanged", hi_o, 32'd3);
    repeat (40) @(posedge clk_i);
    #1 check(done_o == 1'b0 && lo_o == 32'd22, "R5 no second run", lo_o, 32'd22);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 test_reset();
    rst_ni = 1'b1;
    test_unsigned();
    test_signed();
    test_zero_div();
    test_hold();
    test_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule